// File: doc/BRIEF.md
# I2C Master Line Sequencer

This block produces the clock and data line drive for the master side of an I2C bus. Every interval is counted in cycles of the single system clock. It forms start, repeated-start and stop conditions and the low and high phases of each data bit. Line drive is open-drain style: a pin enable of 1 pulls the line low, and 0 releases it so the external pull-up brings it high. The clock and data lines are read back through a synchronizer that runs on the system clock.

A controller loads the SCL period into `period_cfg`. It then issues single-cycle strobes to open the bus, to restart it or to close it. Data bits stream in over a valid/ready handshake. A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. The producer must hold `bit_valid` and `bit_value` steady until that edge. When no bit is offered at the end of a phase, the block parks with SCL held low and waits; this is its only form of back-pressure. A close request that arrives before the opening condition has actually appeared on the lines is kept pending. The block acts on it only once it sees both lines low.

Let P be the latched period, H = floor(P/2) the high phase and L = P - H the low phase.

Top module: `i2c_line_seq`

## Requirements
- R1: The period used is `period_cfg` clamped into [28, 256]. It is captured when an open is accepted from idle, and changes to `period_cfg` while busy have no effect on any interval.
- R2: On an open from idle, SDA is pulled low while SCL stays released for H-1 cycles, and then SCL is pulled low.
- R3: For each bit, SCL is pulled low for L cycles and released for H cycles when bits stream back to back. An odd period puts its extra cycle in the low phase.
- R4: SDA keeps its previous level for 3 cycles after SCL is pulled low, then takes the bit value (`bit_value` 1 = released, 0 = pulled low), giving L-3 cycles of setup before SCL is released.
- R5: On a close, SDA is pulled low during the SCL low phase, then SCL is released. SDA is released H+2 cycles after SCL is released.
- R6: `busy` rises in the same cycle that SDA is first pulled low for an open. After a close releases SDA, `busy` stays high for H-1 more cycles of bus-free time and then falls.
- R7: A restart taken in the parked state releases SDA after the 3-cycle hold while SCL is low. Both lines then stay released for P cycles, and after that an open sequence as in R2 follows.
- R8: A close requested before the parked state is reached is held pending. It runs only after the synchronized SCL reads low, and, if no bit has been sent since the last open, after the synchronized SDA also reads low.
- R9: An open strobe while `busy` is high is ignored, and a restart strobe outside the parked state is ignored; neither changes the line waveform.
- R10: `bit_ready` is high only in the parked state, or in the last cycle of an open hold or of a bit high phase. It is low while a close is requested or pending, and low in the parked state while a restart strobe is present.
- R11: After reset both enables are 0, `busy` is 0 and `bit_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | 9 | Requested SCL period in system-clock cycles |
| open_req | input | 1 | Strobe: send an opening (start) condition |
| restart_req | input | 1 | Strobe: send a repeated start |
| close_req | input | 1 | Strobe: send a closing (stop) condition |
| bit_valid | input | 1 | A data bit is offered |
| bit_value | input | 1 | Offered bit, 1 = SDA released |
| bit_ready | output | 1 | Block can take the offered bit this cycle |
| scl_in | input | 1 | SCL line level as seen on the pin |
| sda_in | input | 1 | SDA line level as seen on the pin |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Bus held by this master |

## Verification
The assertions assume that the strobes are single-cycle pulses and that the pin inputs follow the block's own drive. No other device pulls either line, so the synchronized SCL eventually reads low once it is driven low. The stimulus wires each pin input as the inverse of its pull enable. It holds the offered bit until the handshake completes, and issues restarts only after seeing SCL go low again following a high phase. Periods are drawn at random across the whole legal range and beyond it, and directed runs cover the shortest, longest and odd periods and a close issued during the open hold.

// File: rtl/ilseq_pkg.sv
package ilseq_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE,   // both lines released, not busy
    SQ_OPEN,   // SDA low, SCL released: open hold
    SQ_PARK,   // SCL low, waiting for work
    SQ_BHOLD,  // SCL low, old SDA held
    SQ_BSET,   // SCL low, new SDA set up
    SQ_BHIGH,  // SCL released, data stable
    SQ_CHOLD,  // close: SCL low, old SDA held
    SQ_CSET,   // close: SCL low, SDA low
    SQ_CHIGH,  // close: SCL released, SDA low
    SQ_FREE,   // both released, bus-free wait
    SQ_RHOLD,  // restart: SCL low, old SDA held
    SQ_RSET,   // restart: SCL low, SDA released
    SQ_RHIGH   // restart: both released for a full period
  } sq_state_e;
endpackage

// File: rtl/ilseq_sync.sv
module ilseq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ilseq_phase.sv
module ilseq_phase #(
  parameter int W    = 9,
  parameter int PMIN = 28,
  parameter int PMAX = 256
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] per,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam logic [W-1:0] MINV = W'(PMIN);
  localparam logic [W-1:0] MAXV = W'(PMAX);

  always_comb begin
    if (raw < MINV)      per = MINV;
    else if (raw > MAXV) per = MAXV;
    else                 per = raw;
    hi = per >> 1;
    lo = per - hi;
  end
endmodule

// File: rtl/ilseq_timer.sv
module ilseq_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_line_seq.sv
module i2c_line_seq
  import ilseq_pkg::*;
#(
  parameter int PER_W       = 9,
  parameter int PER_MIN     = 28,
  parameter int PER_MAX     = 256,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_HOLD   = 3,
  parameter int CLOSE_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_cfg,
  input  logic             open_req,
  input  logic             restart_req,
  input  logic             close_req,
  input  logic             bit_valid,
  input  logic             bit_value,
  output logic             bit_ready,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             busy
);
  localparam int TW = PER_W + 1;
  localparam logic [TW-1:0] ONE      = TW'(1);
  localparam logic [TW-1:0] TWO      = TW'(2);
  localparam logic [TW-1:0] HOLD_M1  = TW'(DATA_HOLD - 1);
  localparam logic [TW-1:0] SET_SUB  = TW'(DATA_HOLD + 1);
  localparam logic [TW-1:0] CLOSE_M1 = TW'(CLOSE_EXTRA - 1);

  sq_state_e        state_q, state_n;
  logic [PER_W-1:0] per_q, ph_raw, ph_per, ph_hi, ph_lo;
  logic [TW-1:0]    per_w, hi_w, lo_w, load_val;
  logic [1:0]       pins_s;
  logic             scl_s, sda_s, t_zero;
  logic             close_pend_q, fresh_q, bit_q;
  logic             scl_pull_q, sda_pull_q, busy_q;
  logic             gap_ok, ready_c, take, close_want, close_gate, active;

  // line synchronizer
  ilseq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  // period: live input while idle, latched copy otherwise
  assign ph_raw = (state_q == SQ_IDLE) ? period_cfg : per_q;
  ilseq_phase #(.W(PER_W), .PMIN(PER_MIN), .PMAX(PER_MAX)) u_phase (
    .raw(ph_raw), .per(ph_per), .hi(ph_hi), .lo(ph_lo)
  );
  assign per_w = TW'(ph_per);
  assign hi_w  = TW'(ph_hi);
  assign lo_w  = TW'(ph_lo);

  ilseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(state_n != state_q),
    .load_val(load_val), .zero(t_zero)
  );

  // handshake and close gating
  always_comb begin
    gap_ok     = !close_pend_q && !close_req;
    close_want = close_pend_q || close_req;
    close_gate = !scl_s && (!fresh_q || !sda_s);
    case (state_q)
      SQ_PARK:           ready_c = gap_ok && !restart_req;
      SQ_OPEN, SQ_BHIGH: ready_c = t_zero && gap_ok;
      default:           ready_c = 1'b0;
    endcase
    take = bit_valid && ready_c;
  end

  always_comb begin
    state_n = state_q;
    case (state_q)
      SQ_IDLE:           if (open_req) state_n = SQ_OPEN;
      SQ_OPEN, SQ_BHIGH: if (t_zero) state_n = take ? SQ_BHOLD : SQ_PARK;
      SQ_PARK: begin
        if (close_want && close_gate)      state_n = SQ_CHOLD;
        else if (!close_want && restart_req) state_n = SQ_RHOLD;
        else if (take)                     state_n = SQ_BHOLD;
      end
      SQ_BHOLD: if (t_zero) state_n = SQ_BSET;
      SQ_BSET:  if (t_zero) state_n = SQ_BHIGH;
      SQ_CHOLD: if (t_zero) state_n = SQ_CSET;
      SQ_CSET:  if (t_zero) state_n = SQ_CHIGH;
      SQ_CHIGH: if (t_zero) state_n = SQ_FREE;
      SQ_FREE:  if (t_zero) state_n = SQ_IDLE;
      SQ_RHOLD: if (t_zero) state_n = SQ_RSET;
      SQ_RSET:  if (t_zero) state_n = SQ_RHIGH;
      SQ_RHIGH: if (t_zero) state_n = SQ_OPEN;
      default:  state_n = SQ_IDLE;
    endcase
  end

  // interval of the state being entered, minus one
  always_comb begin
    case (state_n)
      SQ_OPEN, SQ_FREE:             load_val = hi_w - TWO;
      SQ_BHOLD, SQ_CHOLD, SQ_RHOLD: load_val = HOLD_M1;
      SQ_BSET, SQ_CSET, SQ_RSET:    load_val = lo_w - SET_SUB;
      SQ_BHIGH:                     load_val = hi_w - ONE;
      SQ_CHIGH:                     load_val = hi_w + CLOSE_M1;
      SQ_RHIGH:                     load_val = per_w - ONE;
      default:                      load_val = '0;
    endcase
  end

  always_comb begin
    case (state_q)
      SQ_IDLE, SQ_CHOLD, SQ_CSET, SQ_CHIGH, SQ_FREE: active = 1'b0;
      default:                                       active = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SQ_IDLE;
      per_q        <= PER_W'(PER_MIN);
      close_pend_q <= 1'b0;
      fresh_q      <= 1'b0;
      bit_q        <= 1'b1;
      busy_q       <= 1'b0;
      scl_pull_q   <= 1'b0;
      sda_pull_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= (state_n != SQ_IDLE);
      if (state_q == SQ_IDLE && open_req) per_q <= ph_per;
      if (take) bit_q <= bit_value;

      if (state_n == SQ_CHOLD)              close_pend_q <= 1'b0;
      else if (close_req && active)         close_pend_q <= 1'b1;

      if (state_n == SQ_OPEN && state_q != SQ_OPEN) fresh_q <= 1'b1;
      else if (state_n == SQ_BHOLD)                 fresh_q <= 1'b0;

      case (state_n)
        SQ_PARK, SQ_BHOLD, SQ_BSET, SQ_CHOLD, SQ_CSET, SQ_RHOLD, SQ_RSET:
          scl_pull_q <= 1'b1;
        default: scl_pull_q <= 1'b0;
      endcase

      case (state_n)
        SQ_IDLE, SQ_FREE, SQ_RSET, SQ_RHIGH: sda_pull_q <= 1'b0;
        SQ_OPEN, SQ_CSET, SQ_CHIGH:          sda_pull_q <= 1'b1;
        SQ_BSET:                             sda_pull_q <= ~bit_q;
        default:                             sda_pull_q <= sda_pull_q;
      endcase
    end
  end

  assign bit_ready = ready_c;
  assign scl_pull  = scl_pull_q;
  assign sda_pull  = sda_pull_q;
  assign busy      = busy_q;
endmodule

// File: rtl/i2c_line_seq_chk.sv
module i2c_line_seq_chk
  import ilseq_pkg::*;
#(
  parameter int PER_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_pull,
  input logic             sda_pull,
  input logic             busy,
  input logic             bit_ready,
  input logic             scl_s,
  input logic             close_pend_q,
  input logic [PER_W-1:0] per_q,
  input sq_state_e        state_q
);
  AST_BUSY_RISES_WITH_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_pull && !scl_pull)); // R6

  AST_SCL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> busy); // R2

  AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(per_q)); // R1

  AST_SDA_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && (sda_pull != $past(sda_pull)))
      |-> ($past(scl_pull, 1) && $past(scl_pull, 2) && $past(scl_pull, 3))); // R4

  AST_CLOSE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CHOLD && $past(state_q) == SQ_PARK) |-> $past(!scl_s)); // R8

  AST_NO_READY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> !close_pend_q); // R10

  AST_RESTART_FROM_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RHOLD && $past(state_q) != SQ_RHOLD) |-> ($past(state_q) == SQ_PARK)); // R9
endmodule

bind i2c_line_seq i2c_line_seq_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .busy(busy), .bit_ready(bit_ready), .scl_s(scl_s),
  .close_pend_q(close_pend_q), .per_q(per_q), .state_q(state_q)
);

// File: tb/i2c_line_seq_tb.sv
module i2c_line_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] period_cfg = 9'd28;
  logic       open_req = 1'b0, restart_req = 1'b0, close_req = 1'b0;
  logic       bit_valid = 1'b0, bit_value = 1'b0;
  logic       bit_ready, scl_pull, sda_pull, busy;
  logic       scl_in, sda_in;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int seg_scl [64];
  int seg_sda [64];
  int seg_len [64];
  string seg_tag [64];
  int n_seg = 0;

  always #5 clk = ~clk;

  assign scl_in = ~scl_pull;
  assign sda_in = ~sda_pull;

  i2c_line_seq u_dut (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .open_req(open_req),
    .restart_req(restart_req), .close_req(close_req), .bit_valid(bit_valid),
    .bit_value(bit_value), .bit_ready(bit_ready), .scl_in(scl_in),
    .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int clampp(input int raw);
    if (raw < 28) return 28;
    if (raw > 256) return 256;
    return raw;
  endfunction

  // expected segment list, adjacent equal line patterns merged
  function automatic void push(input int s, input int d, input int len, input string tag);
    if (n_seg > 0 && seg_scl[n_seg-1] == s && seg_sda[n_seg-1] == d) begin
      seg_len[n_seg-1] = (seg_len[n_seg-1] < 0 || len < 0) ? -1 : seg_len[n_seg-1] + len;
      seg_tag[n_seg-1] = {seg_tag[n_seg-1], "+", tag};
    end else begin
      seg_scl[n_seg] = s; seg_sda[n_seg] = d; seg_len[n_seg] = len; seg_tag[n_seg] = tag;
      n_seg++;
    end
  endfunction

  task automatic check_runs(input int h);
    for (int i = 0; i < n_seg; i++) begin
      int cnt = 0;
      while (int'(scl_pull) == seg_scl[i] && int'(sda_pull) == seg_sda[i] && cnt < 5000) begin
        cnt++;
        @(negedge clk);
      end
      if (seg_len[i] >= 0) chk(cnt == seg_len[i], seg_tag[i], cnt, seg_len[i]);
      else chk(cnt >= 1 && cnt < 5000, {seg_tag[i], " (open length)"}, cnt, 1);
    end
    begin
      int bcnt = 0;
      while (!scl_pull && !sda_pull && busy && bcnt < 5000) begin
        bcnt++;
        @(negedge clk);
      end
      chk(bcnt == h - 1, "R6 bus-free busy span", bcnt, h - 1);
      chk(!busy && !scl_pull && !sda_pull, "R6 idle after bus-free", int'(busy), 0);
    end
  endtask

  task automatic send_bits(input int nb, input logic [7:0] bits, input bit disturb);
    for (int k = 0; k < nb; k++) begin
      bit_value = bits[k];
      bit_valid = 1'b1;
      #1;
      while (!bit_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      if (k == 0 && disturb) begin
        open_req = 1'b1; restart_req = 1'b1; period_cfg = 9'(28 + $urandom_range(0, 200));
        @(negedge clk);
        open_req = 1'b0; restart_req = 1'b0;
      end
    end
    bit_valid = 1'b0;
  endtask

  // one bus transaction: open, bits, optional restart and more bits, close
  task automatic txn(input int raw, input int nb, input logic [7:0] b1,
                     input bit rs, input int nb2, input logic [7:0] b2);
    int p = clampp(raw);
    int h = p / 2;
    int l = p - h;
    int prev = 1;
    n_seg = 0;
    push(0, 1, h - 1, "R2 open hold");
    for (int k = 0; k < nb; k++) begin
      push(1, prev, 3, "R4 data hold");
      push(1, b1[k] ? 0 : 1, l - 3, "R4 data setup");
      push(0, b1[k] ? 0 : 1, h, "R3 high phase");
      prev = b1[k] ? 0 : 1;
    end
    if (rs) begin
      push(1, prev, -1, "R7 park");
      push(1, prev, 3, "R7 restart hold");
      push(1, 0, l - 3, "R7 restart release");
      push(0, 0, p, "R7 restart both high");
      push(0, 1, h - 1, "R7 reopen hold");
      prev = 1;
      for (int k = 0; k < nb2; k++) begin
        push(1, prev, 3, "R4 data hold");
        push(1, b2[k] ? 0 : 1, l - 3, "R4 data setup");
        push(0, b2[k] ? 0 : 1, h, "R3 high phase");
        prev = b2[k] ? 0 : 1;
      end
    end
    push(1, prev, -1, "R8 park before close");
    push(1, prev, 3, "R5 close hold");
    push(1, 1, l - 3, "R5 close low");
    push(0, 1, h + 2, "R5 stop setup");

    @(negedge clk);
    chk(!busy, "R6 busy low before open", int'(busy), 0);
    period_cfg = 9'(raw);
    open_req = 1'b1;
    @(negedge clk);
    open_req = 1'b0;
    chk(busy && sda_pull && !scl_pull, "R6 busy rises with SDA fall", int'(busy), 1);
    fork
      check_runs(h);
      begin
        if (nb == 0) begin
          close_req = 1'b1;          // close during the open hold: deferred
          @(negedge clk);
          close_req = 1'b0;
        end else begin
          send_bits(nb, b1, 1'b1);
          if (rs) begin
            while (scl_pull) @(negedge clk);
            while (!scl_pull) @(negedge clk);
            restart_req = 1'b1;
            @(negedge clk);
            restart_req = 1'b0;
            send_bits(nb2, b2, 1'b0);
          end
          close_req = 1'b1;
          @(negedge clk);
          close_req = 1'b0;
        end
      end
    join
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R11 lines released in reset", int'(scl_pull), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R11 busy low after reset", int'(busy), 0);
    chk(!bit_ready, "R11 ready low after reset", int'(bit_ready), 0);
    // R9: restart while idle is ignored
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_pull && !sda_pull, "R9 idle restart ignored", int'(busy), 0);

    txn(28, 2, 8'b01, 1'b0, 0, 8'h0);        // R3 shortest period
    txn(29, 3, 8'b101, 1'b0, 0, 8'h0);       // R3 odd period, extra cycle low
    txn(256, 1, 8'b0, 1'b0, 0, 8'h0);        // longest period
    txn(5, 2, 8'b10, 1'b0, 0, 8'h0);         // R1 clamp up
    txn(400, 1, 8'b1, 1'b0, 0, 8'h0);        // R1 clamp down
    txn(40, 0, 8'h0, 1'b0, 0, 8'h0);         // R8 close during open hold
    txn(33, 2, 8'b11, 1'b1, 2, 8'b00);       // R7 restart
    for (int t = 0; t < 10; t++) begin
      int raw = 20 + $urandom_range(0, 250);
      int nb = 1 + $urandom_range(0, 3);
      bit rs = 1'($urandom_range(0, 1));
      txn(raw, nb, 8'($urandom), rs, 1 + $urandom_range(0, 2), 8'($urandom));
    end
    summary();
    $finish;
  end
endmodule